// File: doc/BRIEF.md
# Registered Seven-Operation Integer ALU

A 32-bit integer unit that takes two operands and a 3-bit operation select, computes one of seven functions, and registers the outcome. A request is made by raising `go` for a cycle; the unit samples the operands and the select on that clock edge and, on the same edge, loads the result register and raises `done` for exactly one cycle. The result stays on `res` until the next request.

The select is decoded as follows: 0 gives a AND b, 1 gives a OR b, 2 gives NOT a, 3 gives a + b, 4 gives a − b, 5 shifts a left by one bit, 6 shifts a right by one bit, and 7 gives zero. NOT and both shifts use operand a only and do not depend on operand b at all. Add and subtract wrap modulo 2^32 and have no carry output. Both shifts are logical and fill the vacated bit with zero.

Top module: `alu7_unit`

## Requirements
- R1: After reset, `res` is 0 and `done` is 0.
- R2: Select 0 yields a AND b; select 1 yields a OR b.
- R3: Select 2 yields the bitwise complement of a, and the result does not depend on b.
- R4: Select 3 yields (a + b) mod 2^32; select 4 yields (a − b) mod 2^32. Carries and borrows out of bit 31 are dropped.
- R5: Select 5 yields a shifted left by one bit with bit 0 set to 0; select 6 yields a shifted right by one bit with bit 31 set to 0. Neither result depends on b.
- R6: Select 7 yields 0 for every a and b.
- R7: When `go` is high at a rising edge, `res` shows the result computed from that edge's inputs right after that edge, and `done` is high for that one cycle only. When `go` is low at an edge, `done` is low after that edge.
- R8: While `go` is low, `res` keeps its value, whatever happens on `a`, `b` and `op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Request strobe; samples a, b and op |
| op | input | 3 | Operation select |
| a | input | 32 | First operand |
| b | input | 32 | Second operand, ignored by selects 2, 5 and 6 |
| res | output | 32 | Registered result |
| done | output | 1 | One-cycle pulse that marks a new result |

## Verification
The bench aims at wrap-around cases. All-ones plus one must give zero, and zero minus one must give all ones; a design that kept a 33rd bit, or that subtracted in the wrong order, returns the wrong value. It puts a 1 in bit 31 or bit 0 before a shift, which shows up a rotate where a shift is needed, or an arithmetic right shift that copies the sign bit. For selects 2, 5 and 6 it drives a random b, which exposes any path from operand b into a unary result. It also holds `go` low for several cycles while the inputs change, so a result register that kept loading would show a new value, and it repeats `go` on back-to-back cycles, so a `done` stuck high or an extra pulse would be seen.

// File: rtl/alu7_pkg.sv
package alu7_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_NOT  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_NONE = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          done;
    } alu_state_t;
endpackage

// File: rtl/alu7_logic.sv
module alu7_logic
    import alu7_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] not_o
);
    always_comb begin
        and_o = a & b;
        or_o  = a | b;
        not_o = ~a;
    end

    always_comb begin
        assert_not_ignores_b_R3: assert (not_o == ~a);
    end
endmodule

// File: rtl/alu7_arith.sv
module alu7_arith
    import alu7_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] diff_o
);
    logic [W-1:0] b_inv;
    always_comb begin
        b_inv  = ~b;
        sum_o  = a + b;
        diff_o = a + b_inv + W'(1);
    end

    always_comb begin
        assert_sub_inverts_add_R4: assert (diff_o + b == a);
    end
endmodule

// File: rtl/alu7_shift.sv
module alu7_shift
    import alu7_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] shl_o,
    output logic [W-1:0] shr_o
);
    always_comb begin
        shl_o = {a[W-2:0], 1'b0};
        shr_o = {1'b0, a[W-1:1]};
    end

    always_comb begin
        assert_shift_fill_zero_R5: assert (shl_o[0] == 1'b0 && shr_o[W-1] == 1'b0);
    end
endmodule

// File: rtl/alu7_unit.sv
module alu7_unit
    import alu7_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [2:0]    op,
    input  logic [31:0]   a,
    input  logic [31:0]   b,
    output logic [31:0]   res,
    output logic          done
);
    logic [DW-1:0] and_w, or_w, not_w, sum_w, diff_w, shl_w, shr_w;
    logic [DW-1:0] pick_w;
    alu_state_t    st_d, st_q;

    alu7_logic #(.W(DW)) u_logic (
        .a(a), .b(b), .and_o(and_w), .or_o(or_w), .not_o(not_w)
    );
    alu7_arith #(.W(DW)) u_arith (
        .a(a), .b(b), .sum_o(sum_w), .diff_o(diff_w)
    );
    alu7_shift #(.W(DW)) u_shift (
        .a(a), .shl_o(shl_w), .shr_o(shr_w)
    );

    always_comb begin
        unique case (alu_op_e'(op))
            OP_AND:  pick_w = and_w;
            OP_OR:   pick_w = or_w;
            OP_NOT:  pick_w = not_w;
            OP_ADD:  pick_w = sum_w;
            OP_SUB:  pick_w = diff_w;
            OP_SHL:  pick_w = shl_w;
            OP_SHR:  pick_w = shr_w;
            default: pick_w = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = go;
        if (go) st_d.res = pick_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res  = st_q.res;
    assign done = st_q.done;

    assert_done_follows_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done);
    assert_done_low_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !done);
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(res));
    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == 3'd7) |=> res == '0);
    assert_and_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == 3'd0) |=> res == ($past(a) & $past(b)));
endmodule

// File: tb/alu7_unit_bench.sv
module alu7_unit_bench;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [2:0] op = '0;
    logic [31:0] a = '0, b = '0;
    logic [31:0] res;
    logic done;
    int checks = 0, fails = 0;
    logic [31:0] last;

    alu7_unit u_alu7_unit (.clk(clk), .rst_n(rst_n), .go(go), .op(op),
        .a(a), .b(b), .res(res), .done(done));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
        case (o)
            3'd0: return x & y;
            3'd1: return x | y;
            3'd2: return ~x;
            3'd3: return x + y;
            3'd4: return x - y;
            3'd5: return x << 1;
            3'd6: return x >> 1;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5, 3'd6: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        go = 1'b1; op = o; a = x; b = y;
        @(negedge clk);
        go = 1'b0;
        check(tag(o), res, model(o, x, y));
        check("R7", {31'd0, done}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1", res, 32'd0);
        check("R1", {31'd0, done}, 32'd0);
        rst_n = 1'b1;

        issue(3'd0, 32'hF0F0_1234, 32'h0FF0_FFFF);
        issue(3'd1, 32'hF000_0000, 32'h0000_000F);
        issue(3'd2, 32'h1234_5678, 32'hFFFF_FFFF);
        issue(3'd3, 32'hFFFF_FFFF, 32'h0000_0001);
        issue(3'd4, 32'h0000_0000, 32'h0000_0001);
        issue(3'd4, 32'h0000_0010, 32'h0000_0003);
        issue(3'd5, 32'h8000_0001, 32'hDEAD_BEEF);
        issue(3'd6, 32'h8000_0001, 32'hDEAD_BEEF);
        issue(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R3 / R5: b varied with same a
        for (int i = 0; i < 3; i++) begin
            for (int k = 0; k < 4; k++) issue(3'(2 + (i == 0 ? 0 : i + 2)), 32'hA5A5_C3C3, $urandom);
        end

        // idle: R7 done low, R8 hold
        @(negedge clk);
        last = res;
        for (int i = 0; i < 5; i++) begin
            op = 3'($urandom); a = $urandom; b = $urandom;
            @(negedge clk);
            check("R8", res, last);
            check("R7", {31'd0, done}, 32'd0);
        end

        // back-to-back go
        @(negedge clk);
        go = 1'b1; op = 3'd3; a = 32'd5; b = 32'd6;
        @(negedge clk);
        check("R4", res, 32'd11);
        check("R7", {31'd0, done}, 32'd1);
        op = 3'd4; a = 32'd5; b = 32'd6;
        @(negedge clk);
        go = 1'b0;
        check("R4", res, 32'hFFFF_FFFF);
        check("R7", {31'd0, done}, 32'd1);
        @(negedge clk);
        check("R7", {31'd0, done}, 32'd0);

        for (int i = 0; i < 300; i++) begin
            issue(3'($urandom), $urandom, $urandom);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule